// File: doc/BRIEF.md
# Terminal-Side S/T Layer-1 Activation Controller

This block runs the layer-1 activation and deactivation sequence for the terminal end of a four-wire ISDN basic-rate S/T interface. A front end that is not part of this block detects the line signals. It reports them as five flags: INFO0 seen, any signal present, INFO2 identified, INFO4 identified, and synchronism lost. From these flags and a 4-bit command code written by the host, the controller picks the INFO signal to send on the line and returns a 4-bit indication code to the host. It also drives a clock-enable output that lets the terminal stop its clocks while powered down, and it can send alternating pseudo-ternary test pulses at one of two rates.

Command, flags and configuration are sampled on every rising clock edge. All outputs are registered and follow the state that is entered at that edge. The activation supervision timer is left to host software, so waiting for the network has no time limit. Once the line has gone quiet after an activation, the block stays in a drain state until the line wakes up again or the host explicitly deactivates it.

Top module: `te_act_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to power-down: `l1_state`=000, `tx_info`=00 (INFO0), `ci_ind`=1111, no test pulses, and `clk_en` = NOT `cfg_clk_stop`.
- R2: `clk_en` is low only in power-down (000), and only while `cfg_clk_stop` is 1. In every other case it is high.
- R3: From power-down, command 0000 or `du_low` high moves the block to power-up (001). In power-up it sends INFO0 and indicates 0111.
- R4: Command 1000 (activation request) in power-down or power-up moves the block to pending activation (011). There it sends INFO1 (`tx_info`=01) and indicates 0111.
- R5: Pending activation has no timeout. Without line signal and without command 1111, it holds for any number of cycles.
- R6: `rx_any` in power-down, power-up or pending activation moves the block to unsynchronized (100). It sends INFO0 there and indicates 0100.
- R7: In unsynchronized, INFO4 leads to activated (110, indication 1100) and INFO2 leads to synchronized (101, indication 1000). INFO4 wins if both are present. Both states send INFO3 (`tx_info`=10). INFO4 in synchronized and INFO2 in activated switch between these two states.
- R8: `rx_lost_sync` in synchronized or activated returns the block to unsynchronized.
- R9: INFO0 in unsynchronized, synchronized or activated moves the block to pending deactivation (010). It sends INFO0 there and indicates 0000. INFO0 wins over lost sync and over INFO2/INFO4.
- R10: Pending deactivation is left only by `rx_any` (to 100, which wins) or by command 1111 (to 000). Commands 0000, 1000, 0010, 0011 and `du_low` leave state, indication and transmit choice unchanged.
- R11: Command 1111 returns power-up (only while `du_low` is low) and pending activation to power-down.
- R12: Command 0010 (2 kHz) or 0011 (96 kHz) in power-down or power-up enters test (111): `tx_info`=11, indication 0010. One-cycle pulses alternate between `line_pos` and `line_neg`, starting with `line_pos`, every CLK_HZ/rate cycles. Command 1111 leaves to 000 and 0000 leaves to 001. There are no pulses outside test.
- R13: `ci_ind` changes only in a cycle in which `l1_state` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_clk_stop | input | 1 | Allow the clock enable to drop in power-down |
| ci_cmd | input | 4 | Host command code |
| du_low | input | 1 | Host command line held statically low |
| rx_info0 | input | 1 | INFO0 detected |
| rx_any | input | 1 | Any line signal detected |
| rx_info2 | input | 1 | INFO2 identified |
| rx_info4 | input | 1 | INFO4 identified |
| rx_lost_sync | input | 1 | Frame synchronism lost |
| ci_ind | output | 4 | Indication code to host |
| tx_info | output | 2 | Transmitted signal: 00 INFO0, 01 INFO1, 10 INFO3, 11 test pattern |
| line_pos | output | 1 | Positive test pulse |
| line_neg | output | 1 | Negative test pulse |
| clk_en | output | 1 | Clock enable for the terminal |
| l1_state | output | 3 | Current layer-1 state code |

## Verification
Directed sequences walk each transition with exactly one flag or command active. This separates the individual exits of each state. Further patterns raise conflicting flags together (INFO2 with INFO4, INFO0 with lost sync) and apply commands that must be ignored in pending deactivation, so priority errors and missing guards show up. A long pending-activation hold and test-pulse trains in both modes check timing: they catch a hidden timeout, a wrong divider and broken polarity alternation. Seeded random commands and sparse flags then exercise mixed orderings against a state model in the bench.

// File: rtl/te_act_pkg.sv
package te_act_pkg;

  localparam int CI_W = 4;

  typedef enum logic [2:0] {
    ST_DOWN   = 3'd0,
    ST_UP     = 3'd1,
    ST_DRAIN  = 3'd2,
    ST_REQ    = 3'd3,
    ST_SEEK   = 3'd4,
    ST_SYNC   = 3'd5,
    ST_ACTIVE = 3'd6,
    ST_TEST   = 3'd7
  } l1_state_e;

  typedef enum logic [1:0] {
    TX_I0   = 2'd0,
    TX_I1   = 2'd1,
    TX_I3   = 2'd2,
    TX_TPAT = 2'd3
  } tx_sel_e;

  localparam logic [CI_W-1:0] CMD_TIM = 4'h0;
  localparam logic [CI_W-1:0] CMD_TM1 = 4'h2;
  localparam logic [CI_W-1:0] CMD_TM2 = 4'h3;
  localparam logic [CI_W-1:0] CMD_AR  = 4'h8;
  localparam logic [CI_W-1:0] CMD_DI  = 4'hF;

  localparam logic [CI_W-1:0] IND_IDLE    = 4'hF;
  localparam logic [CI_W-1:0] IND_PWRUP   = 4'h7;
  localparam logic [CI_W-1:0] IND_SEEK    = 4'h4;
  localparam logic [CI_W-1:0] IND_SIGRX   = 4'h8;
  localparam logic [CI_W-1:0] IND_ACTIVE  = 4'hC;
  localparam logic [CI_W-1:0] IND_DEACREQ = 4'h0;
  localparam logic [CI_W-1:0] IND_TEST    = 4'h2;

  typedef struct packed {
    logic info0;
    logic any;
    logic info2;
    logic info4;
    logic lost;
  } rx_flags_t;

  function automatic logic [CI_W-1:0] ind_of(input l1_state_e s);
    case (s)
      ST_DOWN:   return IND_IDLE;
      ST_UP:     return IND_PWRUP;
      ST_REQ:    return IND_PWRUP;
      ST_SEEK:   return IND_SEEK;
      ST_SYNC:   return IND_SIGRX;
      ST_ACTIVE: return IND_ACTIVE;
      ST_DRAIN:  return IND_DEACREQ;
      default:   return IND_TEST;
    endcase
  endfunction

  function automatic tx_sel_e tx_of(input l1_state_e s);
    case (s)
      ST_REQ:              return TX_I1;
      ST_SYNC, ST_ACTIVE:  return TX_I3;
      ST_TEST:             return TX_TPAT;
      default:             return TX_I0;
    endcase
  endfunction

endpackage

// File: rtl/te_act_fsm.sv
module te_act_fsm
  import te_act_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [CI_W-1:0] cmd,
  input  logic            du_low,
  input  rx_flags_t       rx,
  output l1_state_e       state_q,
  output l1_state_e       state_nxt,
  output logic            tm2_nxt
);

  logic tm2_q;
  logic is_tm;

  assign is_tm = (cmd == CMD_TM1) || (cmd == CMD_TM2);

  always_comb begin
    state_nxt = state_q;
    case (state_q)
      ST_DOWN: begin
        if (is_tm)                            state_nxt = ST_TEST;
        else if (cmd == CMD_AR)               state_nxt = ST_REQ;
        else if (rx.any)                      state_nxt = ST_SEEK;
        else if (cmd == CMD_TIM || du_low)    state_nxt = ST_UP;
      end
      ST_UP: begin
        if (is_tm)                            state_nxt = ST_TEST;
        else if (cmd == CMD_AR)               state_nxt = ST_REQ;
        else if (rx.any)                      state_nxt = ST_SEEK;
        else if (cmd == CMD_DI && !du_low)    state_nxt = ST_DOWN;
      end
      ST_REQ: begin
        if (rx.any)                           state_nxt = ST_SEEK;
        else if (cmd == CMD_DI)               state_nxt = ST_DOWN;
      end
      ST_SEEK: begin
        if (rx.info0)                         state_nxt = ST_DRAIN;
        else if (rx.info4)                    state_nxt = ST_ACTIVE;
        else if (rx.info2)                    state_nxt = ST_SYNC;
      end
      ST_SYNC: begin
        if (rx.info0)                         state_nxt = ST_DRAIN;
        else if (rx.lost)                     state_nxt = ST_SEEK;
        else if (rx.info4)                    state_nxt = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (rx.info0)                         state_nxt = ST_DRAIN;
        else if (rx.lost)                     state_nxt = ST_SEEK;
        else if (rx.info2)                    state_nxt = ST_SYNC;
      end
      ST_DRAIN: begin
        if (rx.any)                           state_nxt = ST_SEEK;
        else if (cmd == CMD_DI)               state_nxt = ST_DOWN;
      end
      default: begin
        if (cmd == CMD_DI)                    state_nxt = ST_DOWN;
        else if (cmd == CMD_TIM)              state_nxt = ST_UP;
      end
    endcase
  end

  assign tm2_nxt = (state_nxt == ST_TEST && is_tm) ? (cmd == CMD_TM2) : tm2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_DOWN;
      tm2_q   <= 1'b0;
    end else begin
      state_q <= state_nxt;
      tm2_q   <= tm2_nxt;
    end
  end

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REQ && !rx.any && cmd != CMD_DI) |=> state_q == ST_REQ)
    else $error("pending activation left without cause");

  assert_drain_exit_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DRAIN) |=> (state_q == ST_DRAIN || state_q == ST_SEEK || state_q == ST_DOWN))
    else $error("illegal exit from pending deactivation");

  assert_lost_sync_R8: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_SYNC || state_q == ST_ACTIVE) && rx.lost && !rx.info0) |=> state_q == ST_SEEK)
    else $error("lost sync not handled");

  assert_info0_R9: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_SEEK || state_q == ST_SYNC || state_q == ST_ACTIVE) && rx.info0) |=> state_q == ST_DRAIN)
    else $error("INFO0 did not start deactivation");

endmodule

// File: rtl/te_act_out.sv
module te_act_out
  import te_act_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_clk_stop,
  input  l1_state_e       state_q,
  input  l1_state_e       state_nxt,
  output logic [CI_W-1:0] ind,
  output tx_sel_e         tx,
  output logic            clk_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ind    <= IND_IDLE;
      tx     <= TX_I0;
      clk_en <= !cfg_clk_stop;
    end else begin
      if (state_nxt != state_q) ind <= ind_of(state_nxt);
      tx     <= tx_of(state_nxt);
      clk_en <= !(state_nxt == ST_DOWN && cfg_clk_stop);
    end
  end

  assert_ind_on_change_R13: assert property (@(posedge clk) disable iff (rst)
    $stable(state_q) |-> $stable(ind))
    else $error("indication changed without transition");

  assert_clk_gate_R2: assert property (@(posedge clk) disable iff (rst)
    !clk_en |-> state_q == ST_DOWN)
    else $error("clock stopped outside power-down");

  assert_req_info1_R4: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_REQ |-> tx == TX_I1)
    else $error("pending activation not sending INFO1");

endmodule

// File: rtl/te_test_pulse.sv
module te_test_pulse #(
  parameter int DIV1 = 768,
  parameter int DIV2 = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic sel2,
  output logic pos,
  output logic neg
);

  localparam int DMAX = (DIV1 > DIV2) ? DIV1 : DIV2;
  localparam int CW   = (DMAX > 2) ? $clog2(DMAX) : 1;
  localparam logic [CW-1:0] LIM1 = CW'(DIV1 - 1);
  localparam logic [CW-1:0] LIM2 = CW'(DIV2 - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          pol;

  assign lim = sel2 ? LIM2 : LIM1;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      pol <= 1'b0;
      pos <= 1'b0;
      neg <= 1'b0;
    end else if (cnt >= lim) begin
      cnt <= '0;
      pos <= !pol;
      neg <= pol;
      pol <= !pol;
    end else begin
      cnt <= cnt + 1'b1;
      pos <= 1'b0;
      neg <= 1'b0;
    end
  end

  assert_pulse_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(pos && neg))
    else $error("both pulse polarities active");

endmodule

// File: rtl/te_act_ctrl.sv
module te_act_ctrl
  import te_act_pkg::*;
#(
  parameter int CLK_HZ = 1536000,
  parameter int TM1_HZ = 2000,
  parameter int TM2_HZ = 96000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_clk_stop,
  input  logic [3:0] ci_cmd,
  input  logic       du_low,
  input  logic       rx_info0,
  input  logic       rx_any,
  input  logic       rx_info2,
  input  logic       rx_info4,
  input  logic       rx_lost_sync,
  output logic [3:0] ci_ind,
  output logic [1:0] tx_info,
  output logic       line_pos,
  output logic       line_neg,
  output logic       clk_en,
  output logic [2:0] l1_state
);

  localparam int DIV1 = CLK_HZ / TM1_HZ;
  localparam int DIV2 = CLK_HZ / TM2_HZ;

  rx_flags_t rx;
  l1_state_e state_q;
  l1_state_e state_nxt;
  logic      tm2_nxt;
  tx_sel_e   tx;

  assign rx = '{info0: rx_info0, any: rx_any, info2: rx_info2,
                info4: rx_info4, lost: rx_lost_sync};

  te_act_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cmd       (ci_cmd),
    .du_low    (du_low),
    .rx        (rx),
    .state_q   (state_q),
    .state_nxt (state_nxt),
    .tm2_nxt   (tm2_nxt)
  );

  te_act_out u_out (
    .clk          (clk),
    .rst          (rst),
    .cfg_clk_stop (cfg_clk_stop),
    .state_q      (state_q),
    .state_nxt    (state_nxt),
    .ind          (ci_ind),
    .tx           (tx),
    .clk_en       (clk_en)
  );

  te_test_pulse #(.DIV1(DIV1), .DIV2(DIV2)) u_pulse (
    .clk  (clk),
    .rst  (rst),
    .run  (state_nxt == ST_TEST),
    .sel2 (tm2_nxt),
    .pos  (line_pos),
    .neg  (line_neg)
  );

  assign tx_info  = tx;
  assign l1_state = state_q;

  assert_pulse_in_test_R12: assert property (@(posedge clk) disable iff (rst)
    (line_pos || line_neg) |-> (state_q == ST_TEST && tx == TX_TPAT))
    else $error("test pulse outside test state");

endmodule

// File: tb/sim_te_act_ctrl.sv
`timescale 1ns/1ps
module sim_te_act_ctrl;

  localparam int CLK_HZ = 1536000;
  localparam int DIV1 = CLK_HZ / 2000;
  localparam int DIV2 = CLK_HZ / 96000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_clk_stop = 1'b1;
  logic [3:0] ci_cmd = 4'hF;
  logic du_low = 1'b0, rx_info0 = 1'b0, rx_any = 1'b0, rx_info2 = 1'b0;
  logic rx_info4 = 1'b0, rx_lost_sync = 1'b0;
  logic [3:0] ci_ind;
  logic [1:0] tx_info;
  logic line_pos, line_neg, clk_en;
  logic [2:0] l1_state;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [2:0] m_st;
  logic [3:0] m_ind;
  bit watch;
  int exp_div, n_pulse, last_cyc, cyc;
  logic last_pos;

  always #5 clk = ~clk;

  te_act_ctrl #(.CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rst(rst), .cfg_clk_stop(cfg_clk_stop), .ci_cmd(ci_cmd),
    .du_low(du_low), .rx_info0(rx_info0), .rx_any(rx_any), .rx_info2(rx_info2),
    .rx_info4(rx_info4), .rx_lost_sync(rx_lost_sync), .ci_ind(ci_ind),
    .tx_info(tx_info), .line_pos(line_pos), .line_neg(line_neg),
    .clk_en(clk_en), .l1_state(l1_state)
  );

  function automatic logic [2:0] model_nxt(input logic [2:0] s, input logic [3:0] c,
      input logic du, a, i0, i2, i4, ls);
    logic tm;
    tm = (c == 4'h2) || (c == 4'h3);
    case (s)
      3'd0: if (tm) return 3'd7; else if (c == 4'h8) return 3'd3;
            else if (a) return 3'd4; else if (c == 4'h0 || du) return 3'd1;
      3'd1: if (tm) return 3'd7; else if (c == 4'h8) return 3'd3;
            else if (a) return 3'd4; else if (c == 4'hF && !du) return 3'd0;
      3'd3: if (a) return 3'd4; else if (c == 4'hF) return 3'd0;
      3'd4: if (i0) return 3'd2; else if (i4) return 3'd6; else if (i2) return 3'd5;
      3'd5: if (i0) return 3'd2; else if (ls) return 3'd4; else if (i4) return 3'd6;
      3'd6: if (i0) return 3'd2; else if (ls) return 3'd4; else if (i2) return 3'd5;
      3'd2: if (a) return 3'd4; else if (c == 4'hF) return 3'd0;
      default: if (c == 4'hF) return 3'd0; else if (c == 4'h0) return 3'd1;
    endcase
    return s;
  endfunction

  function automatic logic [3:0] exp_ind(input logic [2:0] s);
    case (s)
      3'd0: return 4'hF;
      3'd1, 3'd3: return 4'h7;
      3'd2: return 4'h0;
      3'd4: return 4'h4;
      3'd5: return 4'h8;
      3'd6: return 4'hC;
      default: return 4'h2;
    endcase
  endfunction

  function automatic logic [1:0] exp_tx(input logic [2:0] s);
    case (s)
      3'd3: return 2'd1;
      3'd5, 3'd6: return 2'd2;
      3'd7: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] s);
    case (s)
      3'd0: return "R11";
      3'd1: return "R3";
      3'd2: return "R9";
      3'd3: return "R4";
      3'd4: return "R6";
      3'd5, 3'd6: return "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic compare(input string tag);
    logic exp_clk;
    bit pulses_ok;
    exp_clk = !(m_st == 3'd0 && cfg_clk_stop);
    pulses_ok = (m_st == 3'd7) || (!line_pos && !line_neg);
    check(l1_state == m_st && ci_ind == m_ind && tx_info == exp_tx(m_st) &&
          clk_en == exp_clk && pulses_ok, tag, "state/ind/tx/clk_en/pulse",
          {l1_state, ci_ind, 2'b0, tx_info, 3'b0, clk_en, 3'b0, line_pos|line_neg},
          {m_st, m_ind, 2'b0, exp_tx(m_st), 3'b0, exp_clk, 4'b0});
  endtask

  task automatic step(input logic [3:0] c, input logic du, a, i0, i2, i4, ls,
                      input string tag);
    logic [2:0] ns;
    ci_cmd = c; du_low = du; rx_any = a; rx_info0 = i0;
    rx_info2 = i2; rx_info4 = i4; rx_lost_sync = ls;
    ns = model_nxt(m_st, c, du, a, i0, i2, i4, ls);
    if (ns != m_st) m_ind = exp_ind(ns);  // R13: indication moves only with state
    m_st = ns;
    @(posedge clk); #1;
    cyc++;
    compare(tag);
    if (watch && (line_pos || line_neg)) begin
      if (n_pulse == 0)
        check(line_pos === 1'b1, "R12", "first pulse polarity", line_pos, 1);
      else begin
        check(cyc - last_cyc == exp_div, "R12", "pulse spacing", cyc - last_cyc, exp_div);
        check(line_pos == !last_pos, "R12", "pulse alternation", line_pos, !last_pos);
      end
      n_pulse++; last_cyc = cyc; last_pos = line_pos;
    end
    @(negedge clk);
  endtask

  task automatic cmd_only(input logic [3:0] c, input string tag);
    step(c, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic pulse_run(input logic [3:0] c, input int div, input int n);
    watch = 1'b1; exp_div = div; n_pulse = 0;
    for (int i = 0; i < div * n + 2; i++) cmd_only(c, "R12");
    check(n_pulse >= n, "R12", "pulse count", n_pulse, n);
    watch = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    watch = 1'b0; cyc = 0;
    m_st = 3'd0; m_ind = 4'hF;
    repeat (3) @(posedge clk);
    #1;
    compare("R1");
    check(clk_en == 1'b0, "R1", "reset clk_en with stop bit", clk_en, 0);
    @(negedge clk);
    rst = 1'b0;

    // R2: clock gating follows configuration only in power-down
    cfg_clk_stop = 1'b0; cmd_only(4'hF, "R2");
    cfg_clk_stop = 1'b1; cmd_only(4'hF, "R2");
    check(clk_en == 1'b0, "R2", "clk_en in power-down", clk_en, 0);

    // R3 / R11
    cmd_only(4'h0, "R3");
    check(l1_state == 3'd1 && ci_ind == 4'h7, "R3", "power-up by 0000", l1_state, 1);
    cmd_only(4'hF, "R11");
    step(4'hF, 1'b1, 0, 0, 0, 0, 0, "R3");
    step(4'hF, 1'b1, 0, 0, 0, 0, 0, "R11");
    check(l1_state == 3'd1, "R11", "du_low holds power-up", l1_state, 1);
    cmd_only(4'hF, "R11");

    // R4, R5 hold, R13
    cmd_only(4'h8, "R4");
    for (int i = 0; i < 1500; i++) cmd_only(4'h8, "R5/R13");
    check(l1_state == 3'd3 && tx_info == 2'd1, "R5", "still pending activation", l1_state, 3);

    // R6, R7, R8, R9
    step(4'h8, 0, 1, 0, 0, 0, 0, "R6");
    step(4'hF, 0, 0, 0, 1, 0, 0, "R7");
    step(4'hF, 0, 0, 0, 0, 1, 0, "R7");
    check(ci_ind == 4'hC && tx_info == 2'd2, "R7", "activated", ci_ind, 12);
    step(4'hF, 0, 0, 0, 0, 0, 1, "R8");
    step(4'hF, 0, 0, 0, 1, 1, 0, "R7");
    check(l1_state == 3'd6, "R7", "INFO4 over INFO2", l1_state, 6);
    step(4'hF, 0, 0, 0, 1, 0, 0, "R7");
    step(4'hF, 0, 0, 1, 0, 0, 1, "R9");
    check(l1_state == 3'd2 && ci_ind == 4'h0, "R9", "INFO0 over lost sync", l1_state, 2);

    // R10 ignored stimuli, then exits
    cmd_only(4'h0, "R10"); cmd_only(4'h8, "R10"); cmd_only(4'h2, "R10");
    step(4'h3, 1'b1, 0, 0, 0, 0, 0, "R10");
    check(l1_state == 3'd2 && ci_ind == 4'h0 && tx_info == 2'd0, "R10", "drain unchanged",
          l1_state, 2);
    step(4'hF, 0, 1, 0, 0, 0, 0, "R10");
    check(l1_state == 3'd4, "R10", "line activity wins over 1111", l1_state, 4);
    step(4'hF, 0, 0, 1, 0, 0, 0, "R9");
    cmd_only(4'hF, "R10");
    check(l1_state == 3'd0, "R10", "1111 ends drain", l1_state, 0);
    cmd_only(4'h8, "R4");
    cmd_only(4'hF, "R11");
    step(4'hF, 0, 1, 0, 0, 0, 0, "R6");
    step(4'hF, 0, 0, 1, 0, 0, 0, "R9");

    // R12 test modes
    cmd_only(4'hF, "R10");
    cmd_only(4'h3, "R12");
    pulse_run(4'h3, DIV2, 6);
    cmd_only(4'hF, "R12");
    cmd_only(4'h2, "R12");
    pulse_run(4'h2, DIV1, 3);
    cmd_only(4'h0, "R12");
    check(l1_state == 3'd1, "R12", "0000 leaves test to power-up", l1_state, 1);
    cmd_only(4'hF, "R11");

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [3:0] c;
      r = $urandom % 16;
      if (r < 6) c = 4'hF; else if (r < 8) c = 4'h0; else if (r < 10) c = 4'h8;
      else if (r == 10) c = 4'h2; else if (r == 11) c = 4'h3; else if (r == 12) c = 4'h5;
      else c = 4'hF;
      if ($urandom % 8 == 0) cfg_clk_stop = ~cfg_clk_stop;
      step(c, ($urandom % 16) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
           ($urandom % 6) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0, tag_of(m_st));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule